// File: doc/BRIEF.md
# Time-Base Tick and Watchdog Interrupt Unit

This unit derives a periodic time-base tick and a watchdog overflow flag from the system clock. Both come from one shared divider chain. A small prescaler divides the system clock by eight. An eight-stage time-base counter follows it and produces a tick every 8·2^n system clocks, where n is a programmable rate from 0 to 7. The watchdog is a two-stage counter fed by that tick. It overflows on the fourth tick after it was last cleared and sets a sticky flag.

The unit is driven by decoded command strobes, each one clock wide, that come from a serial command front end. The strobes switch the system clock gate on and off, choose whether the interrupt pin shows the tick or the watchdog flag, clear the shared counter, clear the watchdog, enable or disable the interrupt pin, and load the rate. The interrupt is active low. It is paired with an output enable, so a pad can model an open-drain or tristate pin that floats while disabled.

Top module: `tick_wdog_unit`

## Requirements
- R1: After reset the system clock gate is off, `irq_oe` is 0, the pin shows the tick (not the watchdog), and the rate is 0.
- R2: While the system gate is off, the prescaler, the time-base counter, the watchdog and `irq_n` hold their values. No tick occurs, even with the pin enabled.
- R3: With the system running, a tick occurs every 8·2^n clocks, where n is the loaded rate. The first tick comes 8·2^n clocks after a clear-tick or clear-watchdog strobe. Both strobes zero the shared counter.
- R4: In tick mode with the pin enabled, each tick drives `irq_n` low for exactly 8 clocks, starting in the cycle after the tick edge. At rate 0 the pin therefore stays low.
- R5: In watchdog mode, the fourth tick after a clear-watchdog sets the overflow flag. `irq_n` then stays low until a clear-watchdog strobe.
- R6: A clear-watchdog strobe drops the flag and returns `irq_n` high in the next cycle. An IRQ-disable strobe makes `irq_oe` 0 (pin floating).
- R7: An IRQ-enable strobe sets `irq_oe` to 1 from the next cycle. `irq_n` carries meaning only while `irq_oe` is 1.
- R8: When set and clear strobes arrive in the same cycle, the clear wins. System-disable beats system-enable, IRQ-disable beats IRQ-enable, and a clear beats a tick due in that cycle.
- R9: The tick-enable strobe selects tick mode and detaches the watchdog: its stage stops counting and its flag is hidden. If tick-enable and watchdog-enable arrive together, tick mode results.
- R10: The rate-load strobe latches `rate_sel`. The new rate governs the next tick decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the divided-down source of all timing) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_sys_en | input | 1 | Strobe: start the system clock gate |
| cmd_sys_dis | input | 1 | Strobe: stop the system clock gate |
| cmd_tick_en | input | 1 | Strobe: route the time-base tick to the pin |
| cmd_wdog_en | input | 1 | Strobe: route the watchdog flag to the pin |
| cmd_clr_tick | input | 1 | Strobe: zero the shared divider chain |
| cmd_clr_wdog | input | 1 | Strobe: zero the chain, the watchdog stage and its flag |
| cmd_irq_en | input | 1 | Strobe: enable the interrupt pin driver |
| cmd_irq_dis | input | 1 | Strobe: float the interrupt pin |
| cmd_rate_ld | input | 1 | Strobe: load `rate_sel` as the tick rate |
| rate_sel | input | 3 | Tick rate n; the tick period is 8·2^n clocks |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | Pin driver enable; 0 means high impedance |

## Verification
On every cycle the assertions check the following: the pin enable follows its strobes, a disable wins a conflict, the chain is frozen while the system gate is off, the watchdog flag is sticky and is released by its clear, and the flag cannot change in tick mode. The exact tick spacing for each rate, the eight-clock pulse width, overflow on the fourth tick, and the hidden flag after a mode switch can only be seen across many cycles. The bench shows these by following a cycle model of the chain through directed sequences and a long random command stream.

// File: rtl/tick_wdog_pkg.sv
`timescale 1ns/1ps
package tick_wdog_pkg;

   typedef enum logic {
      ROUTE_TICK = 1'b0,
      ROUTE_WDOG = 1'b1
   } irq_route_e;

endpackage

// File: rtl/tick_wdog_ctrl.sv
`timescale 1ns/1ps
// Command state: system gate, pin enable, pin source and tick rate.
// In every set/clear pair the clear strobe wins.
module tick_wdog_ctrl
   import tick_wdog_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_sys_en,
   input  logic             cmd_sys_dis,
   input  logic             cmd_tick_en,
   input  logic             cmd_wdog_en,
   input  logic             cmd_irq_en,
   input  logic             cmd_irq_dis,
   input  logic             cmd_rate_ld,
   input  logic [SEL_W-1:0] rate_sel,
   output logic             sys_on,
   output logic             pin_en,
   output irq_route_e       route,
   output logic [SEL_W-1:0] rate
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_on <= 1'b0;
         pin_en <= 1'b0;
         route  <= ROUTE_TICK;
         rate   <= '0;
      end else begin
         if (cmd_sys_dis)
            sys_on <= 1'b0;
         else if (cmd_sys_en)
            sys_on <= 1'b1;

         if (cmd_irq_dis)
            pin_en <= 1'b0;
         else if (cmd_irq_en)
            pin_en <= 1'b1;

         // tick mode is the safe choice when both arrive together
         if (cmd_tick_en)
            route <= ROUTE_TICK;
         else if (cmd_wdog_en)
            route <= ROUTE_WDOG;

         if (cmd_rate_ld)
            rate <= rate_sel;
      end
   end

endmodule

// File: rtl/tick_wdog_divider.sv
`timescale 1ns/1ps
// Shared chain: prescaler, time-base counter, rate tap and pulse stretcher.
module tick_wdog_divider #(
   parameter int PRE_STAGES = 3,
   parameter int TB_STAGES  = 8,
   parameter int SEL_W      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 clr,
   input  logic [SEL_W-1:0]     rate,
   output logic                 pre_tick,
   output logic [TB_STAGES-1:0] tb_cnt,
   output logic                 tick,
   output logic                 hold
);

   localparam logic [TB_STAGES-1:0] TB_ONE = TB_STAGES'(1);

   logic [TB_STAGES-1:0] tap_mask;
   logic                 raw_tick;

   generate
      if (PRE_STAGES > 0) begin : g_pre
         logic [PRE_STAGES-1:0] pre_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_cnt <= '0;
            else if (clr)
               pre_cnt <= '0;
            else if (run)
               pre_cnt <= pre_cnt + PRE_STAGES'(1);
         end
         assign pre_tick = run & (&pre_cnt);
      end else begin : g_nopre
         assign pre_tick = run;
      end
   endgenerate

   // a tick is the prescaler carry that also carries out of the low n stages
   assign tap_mask = (TB_ONE << rate) - TB_ONE;
   assign raw_tick = pre_tick & ((tb_cnt & tap_mask) == tap_mask);
   assign tick     = raw_tick & ~clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_cnt <= '0;
         hold   <= 1'b0;
      end else if (clr) begin
         tb_cnt <= '0;
         hold   <= 1'b0;
      end else if (pre_tick) begin
         tb_cnt <= tb_cnt + TB_ONE;
         // low for one prescaled period after each tick
         hold   <= raw_tick;
      end
   end

endmodule

// File: rtl/tick_wdog_stage.sv
`timescale 1ns/1ps
// Watchdog stage: counts ticks, sets a sticky flag on wrap-around.
module tick_wdog_stage #(
   parameter int WD_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic flag
);

   logic [WD_STAGES-1:0] wd_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_cnt <= '0;
         flag   <= 1'b0;
      end else if (clr) begin
         wd_cnt <= '0;
         flag   <= 1'b0;
      end else if (step) begin
         wd_cnt <= wd_cnt + WD_STAGES'(1);
         if (&wd_cnt)
            flag <= 1'b1;
      end
   end

endmodule

// File: rtl/tick_wdog_unit.sv
`timescale 1ns/1ps
module tick_wdog_unit
   import tick_wdog_pkg::*;
#(
   parameter int  PRE_STAGES = 3,
   parameter int  TB_STAGES  = 8,
   parameter int  WD_STAGES  = 2,
   localparam int SEL_W      = $clog2(TB_STAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_sys_en,
   input  logic             cmd_sys_dis,
   input  logic             cmd_tick_en,
   input  logic             cmd_wdog_en,
   input  logic             cmd_clr_tick,
   input  logic             cmd_clr_wdog,
   input  logic             cmd_irq_en,
   input  logic             cmd_irq_dis,
   input  logic             cmd_rate_ld,
   input  logic [SEL_W-1:0] rate_sel,
   output logic             irq_n,
   output logic             irq_oe
);

   generate
      if (TB_STAGES < 2 || (TB_STAGES & (TB_STAGES - 1)) != 0) begin : g_bad_tb
         $error("TB_STAGES must be a power of two of at least 2");
      end
      if (PRE_STAGES < 0) begin : g_bad_pre
         $error("PRE_STAGES must not be negative");
      end
      if (WD_STAGES < 1) begin : g_bad_wd
         $error("WD_STAGES must be at least 1");
      end
   endgenerate

   logic                 sys_on;
   logic                 pin_en;
   irq_route_e           route;
   logic [SEL_W-1:0]     rate;
   logic                 chain_clr;
   logic                 pre_tick;
   logic [TB_STAGES-1:0] tb_cnt;
   logic                 tick;
   logic                 hold;
   logic                 wd_flag;
   logic                 irq_act;

   assign chain_clr = cmd_clr_tick | cmd_clr_wdog;

   tick_wdog_ctrl #(.SEL_W(SEL_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_sys_en (cmd_sys_en),
      .cmd_sys_dis(cmd_sys_dis),
      .cmd_tick_en(cmd_tick_en),
      .cmd_wdog_en(cmd_wdog_en),
      .cmd_irq_en (cmd_irq_en),
      .cmd_irq_dis(cmd_irq_dis),
      .cmd_rate_ld(cmd_rate_ld),
      .rate_sel   (rate_sel),
      .sys_on     (sys_on),
      .pin_en     (pin_en),
      .route      (route),
      .rate       (rate)
   );

   tick_wdog_divider #(
      .PRE_STAGES(PRE_STAGES),
      .TB_STAGES (TB_STAGES),
      .SEL_W     (SEL_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (sys_on),
      .clr     (chain_clr),
      .rate    (rate),
      .pre_tick(pre_tick),
      .tb_cnt  (tb_cnt),
      .tick    (tick),
      .hold    (hold)
   );

   tick_wdog_stage #(.WD_STAGES(WD_STAGES)) u_wd (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cmd_clr_wdog),
      .step (tick & (route == ROUTE_WDOG)),
      .flag (wd_flag)
   );

   assign irq_act = (route == ROUTE_WDOG) ? wd_flag : hold;
   assign irq_n   = ~irq_act;
   assign irq_oe  = pin_en;

endmodule

// File: rtl/tick_wdog_chk.sv
`timescale 1ns/1ps
module tick_wdog_chk
   import tick_wdog_pkg::*;
#(
   parameter int TB_STAGES = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_sys_dis,
   input logic                 cmd_clr_tick,
   input logic                 cmd_clr_wdog,
   input logic                 cmd_irq_en,
   input logic                 cmd_irq_dis,
   input logic                 sys_on,
   input logic                 irq_oe,
   input irq_route_e           route,
   input logic [TB_STAGES-1:0] tb_cnt,
   input logic                 hold,
   input logic                 wd_flag
);

   p_pin_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_irq_dis |=> !irq_oe);

   p_pin_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_irq_en && !cmd_irq_dis) |=> irq_oe);

   p_sys_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_sys_dis |=> !sys_on);

   p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_on && !cmd_clr_tick && !cmd_clr_wdog) |=> ($stable(tb_cnt) && $stable(hold)));

   p_chain_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_clr_tick || cmd_clr_wdog) |=> (tb_cnt == '0 && !hold));

   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_flag && !cmd_clr_wdog) |=> wd_flag);

   p_flag_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clr_wdog |=> !wd_flag);

   p_wdog_detached_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (route == ROUTE_TICK && !cmd_clr_wdog) |=> $stable(wd_flag));

endmodule

bind tick_wdog_unit tick_wdog_chk #(.TB_STAGES(TB_STAGES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_sys_dis (cmd_sys_dis),
   .cmd_clr_tick(cmd_clr_tick),
   .cmd_clr_wdog(cmd_clr_wdog),
   .cmd_irq_en  (cmd_irq_en),
   .cmd_irq_dis (cmd_irq_dis),
   .sys_on      (sys_on),
   .irq_oe      (irq_oe),
   .route       (route),
   .tb_cnt      (tb_cnt),
   .hold        (hold),
   .wd_flag     (wd_flag)
);

// File: tb/tick_wdog_unit_tb.sv
`timescale 1ns/1ps
module tick_wdog_unit_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_sys_en = 0, cmd_sys_dis = 0, cmd_tick_en = 0, cmd_wdog_en = 0;
   logic       cmd_clr_tick = 0, cmd_clr_wdog = 0, cmd_irq_en = 0, cmd_irq_dis = 0;
   logic       cmd_rate_ld = 0;
   logic [2:0] rate_sel = '0;
   logic       irq_n;
   logic       irq_oe;

   int    vectors = 0;
   int    errors  = 0;
   bit    done    = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   tick_wdog_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_sys_en(cmd_sys_en), .cmd_sys_dis(cmd_sys_dis),
      .cmd_tick_en(cmd_tick_en), .cmd_wdog_en(cmd_wdog_en),
      .cmd_clr_tick(cmd_clr_tick), .cmd_clr_wdog(cmd_clr_wdog),
      .cmd_irq_en(cmd_irq_en), .cmd_irq_dis(cmd_irq_dis),
      .cmd_rate_ld(cmd_rate_ld), .rate_sel(rate_sel),
      .irq_n(irq_n), .irq_oe(irq_oe)
   );

   // ---- cycle model built from the requirements: elapsed running clocks ----
   bit m_sys, m_oe, m_wd, m_hold, m_flag, m_tick;
   int m_n, m_t, m_wcnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sys = 0; m_oe = 0; m_wd = 0; m_hold = 0; m_flag = 0;
         m_n = 0; m_t = 0; m_wcnt = 0;
      end else begin
         m_tick = 0;
         if (cmd_clr_tick || cmd_clr_wdog) begin
            m_t = 0; m_hold = 0;
         end else if (m_sys) begin
            m_t = (m_t + 1) % 2048;
            if (m_t % 8 == 0) begin
               m_tick = (m_t % (8 << m_n)) == 0;
               m_hold = m_tick;
            end
         end
         if (cmd_clr_wdog) begin
            m_wcnt = 0; m_flag = 0;
         end else if (m_tick && m_wd) begin
            m_wcnt = m_wcnt + 1;
            if (m_wcnt == 4) begin m_wcnt = 0; m_flag = 1; end
         end
         if (cmd_sys_dis) m_sys = 0; else if (cmd_sys_en) m_sys = 1;
         if (cmd_irq_dis) m_oe = 0; else if (cmd_irq_en) m_oe = 1;
         if (cmd_tick_en) m_wd = 0; else if (cmd_wdog_en) m_wd = 1;
         if (cmd_rate_ld) m_n = int'(rate_sel);
      end
   end

   function automatic logic exp_irq_n();
      return m_wd ? !m_flag : !m_hold;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clear_strobes();
      cmd_sys_en = 0; cmd_sys_dis = 0; cmd_tick_en = 0; cmd_wdog_en = 0;
      cmd_clr_tick = 0; cmd_clr_wdog = 0; cmd_irq_en = 0; cmd_irq_dis = 0;
      cmd_rate_ld = 0;
   endtask

   // one observation per clock, away from the rising edge
   task automatic cyc(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         chk({cur_req, " irq_oe"}, int'(irq_oe), int'(m_oe));
         if (m_oe) chk({cur_req, " irq_n"}, int'(irq_n), int'(exp_irq_n()));
         clear_strobes();
      end
   endtask

   task automatic until_level(input logic lvl, input int limit, output int j);
      j = 0;
      while (irq_n !== lvl && j < limit) begin cyc(1); j++; end
   endtask

   initial begin
      int j, lows;
      void'($urandom(20250));
      repeat (3) @(negedge clk);
      // R1: reset values at the ports
      chk("R1 irq_oe after reset", int'(irq_oe), 0);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 irq_oe idle", int'(irq_oe), 0);

      // R2: pin enabled but system never started -> no tick
      cur_req = "R2";
      cmd_irq_en = 1; cmd_clr_tick = 1;
      cyc(1);
      lows = 0;
      for (int i = 0; i < 300; i++) begin cyc(1); if (irq_n === 1'b0) lows++; end
      chk("R2 no tick while stopped", lows, 0);

      // R3/R4: rate 2 -> first tick 32 clocks after clear, 8 clocks low, period 32
      cur_req = "R3";
      cmd_sys_en = 1; cmd_clr_tick = 1; cmd_rate_ld = 1; rate_sel = 3'd2;
      cyc(1);
      until_level(1'b0, 5000, j);
      chk("R3 first tick at rate 2", j, 32);
      cur_req = "R4";
      until_level(1'b1, 5000, j);
      chk("R4 pulse width", j, 8);
      until_level(1'b0, 5000, j);
      chk("R3 tick period rate 2", j + 8, 32);

      // R5: watchdog at rate 0 overflows on 4th tick (32 clocks)
      cur_req = "R5";
      cmd_wdog_en = 1; cmd_clr_wdog = 1; cmd_rate_ld = 1; rate_sel = 3'd0;
      cyc(1);
      until_level(1'b0, 5000, j);
      chk("R5 overflow on fourth tick", j, 32);
      lows = 0;
      for (int i = 0; i < 100; i++) begin cyc(1); if (irq_n === 1'b0) lows++; end
      chk("R5 flag sticky", lows, 100);

      // R6: clear-watchdog releases, disable floats the pin
      cur_req = "R6";
      cmd_clr_wdog = 1;
      cyc(1);
      chk("R6 release after clear", int'(irq_n), 1);
      cmd_irq_dis = 1;
      cyc(1);
      chk("R6 pin floats", int'(irq_oe), 0);

      // R8: conflicting strobes, clear side wins
      cur_req = "R8";
      cmd_sys_en = 1; cmd_sys_dis = 1; cmd_irq_en = 1; cmd_irq_dis = 1;
      cyc(1);
      chk("R8 irq_dis beats irq_en", int'(irq_oe), 0);
      // R7: enable alone; check system stayed off (R8) via absence of ticks
      cur_req = "R7";
      cmd_irq_en = 1; cmd_tick_en = 1; cmd_clr_tick = 1;
      cyc(1);
      chk("R7 pin enabled", int'(irq_oe), 1);
      cur_req = "R8";
      lows = 0;
      for (int i = 0; i < 200; i++) begin cyc(1); if (irq_n === 1'b0) lows++; end
      chk("R8 sys_dis beats sys_en", lows, 0);

      // R2: freeze in mid-pulse at rate 1
      cur_req = "R2";
      cmd_sys_en = 1; cmd_rate_ld = 1; rate_sel = 3'd1;
      cyc(1);
      until_level(1'b0, 5000, j);
      cmd_sys_dis = 1;
      cyc(1);
      lows = 0;
      for (int i = 0; i < 200; i++) begin cyc(1); if (irq_n === 1'b0) lows++; end
      chk("R2 level frozen while stopped", lows, 200);
      cmd_sys_en = 1;
      cyc(1);

      // R9: after overflow, simultaneous route strobes give tick mode
      cur_req = "R9";
      cmd_wdog_en = 1; cmd_clr_wdog = 1;
      cyc(1);
      until_level(1'b0, 5000, j);
      chk("R9 overflow at rate 1", j, 64);
      cmd_tick_en = 1; cmd_wdog_en = 1;
      lows = 0;
      for (int i = 0; i < 16; i++) begin cyc(1); if (irq_n === 1'b1) lows++; end
      chk("R9 flag hidden in tick mode", lows, 8);

      // R10: slowest rate, period 1024
      cur_req = "R10";
      cmd_clr_tick = 1; cmd_rate_ld = 1; rate_sel = 3'd7;
      cyc(1);
      until_level(1'b0, 5000, j);
      chk("R10 first tick at rate 7", j, 1024);

      // random command stream against the model
      cur_req = "R3,R5,R9";
      for (int i = 0; i < 40000; i++) begin
         int r;
         r = int'($urandom % 1000);
         if      (r < 3)  cmd_sys_dis = 1;
         else if (r < 13) cmd_sys_en = 1;
         else if (r < 16) cmd_tick_en = 1;
         else if (r < 19) cmd_wdog_en = 1;
         else if (r < 22) begin cmd_tick_en = 1; cmd_wdog_en = 1; end
         else if (r < 27) cmd_clr_tick = 1;
         else if (r < 30) cmd_clr_wdog = 1;
         else if (r < 33) cmd_irq_en = 1;
         else if (r < 35) cmd_irq_dis = 1;
         else if (r < 37) begin cmd_irq_en = 1; cmd_irq_dis = 1; end
         else if (r < 41) begin
            cmd_rate_ld = 1;
            rate_sel = ($urandom % 5 == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
         end
         else if (r < 42) begin cmd_sys_en = 1; cmd_sys_dis = 1; end
         else if (r < 43) begin cmd_clr_tick = 1; cmd_clr_wdog = 1; end
         cyc(1);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule